// File: doc/BRIEF.md
# Segment Load and Collision Bar Meter

This block watches a shared 100 Mb/s repeater segment and turns its activity into an eight-step bar for a row of eight indicator lines. A free-running window timer divides time into fixed windows. The default window is one second, which is 25,000,000 cycles of the 25 MHz symbol clock. During each window the block counts the clocks on which the receive-activity strobe is high. Each such clock stands for 4 bits, so a window that is fully busy equals 100,000,000 bits, or 100 % load. The block also counts the clocks on which the collision strobe and the receive-activity strobe are both high.

At the last clock of each window the block compares both counts against fixed thresholds and registers two thermometer-coded bars. It then clears the counters. The bars stay frozen for the whole of the next window. The load scale is non-linear: 1, 3, 5, 10, 20, 40, 60 and 80+ %. The collision scale is 1, 2, 4, 6, 8, 10, 15 and 20+ % of active clocks. All comparisons use cross-multiplication, so the block has no divider. A 3-bit select code chooses what the eight lines show: one of the three per-port status vectors, the load bar, or the collision bar.

Top module: `net_load_meter`

## Requirements
- R1: While rst_ni is low, and after it is released until the first window ends, the output is 0 when sel_i is 3 or 4.
- R2: The bars change only on the clock that ends a window. That clock occurs every WIN_CLKS cycles, counted from the first rising edge after reset is released. Between those clocks the bar outputs hold their value.
- R3: Let A be the number of clocks in a window on which rx_act_i is high. Load bit k (led_o[k] when sel_i=3) is 1 exactly when A*100 >= P[k]*WIN_CLKS, where P = {1,3,5,10,20,40,60,80} for k = 0..7.
- R4: Both bars are thermometer codes filled from bit 0 upward. Bit 6 of the load bar marks 60 % and bit 7 marks 80 % or more.
- R5: Let C be the number of clocks on which col_i and rx_act_i are both high, and let A be as in R3. Collision bit k (led_o[k] when sel_i=4) is 1 exactly when A > 0 and C*100 >= Q[k]*A, where Q = {1,2,4,6,8,10,15,20}. Bit 6 marks 15 % and bit 7 marks 20 % or more.
- R6: A window with no receive activity gives an empty collision bar, even if col_i is high during that window.
- R7: The select code maps as follows: 0 shows link_i, 1 shows part_i, 2 shows iso_i, 3 shows the load bar, 4 shows the collision bar, and 5 to 7 drive all lines to 0.
- R8: Counts do not carry from one window into the next. A busy window followed by an idle window gives an empty load bar.
- R9: A clock on which col_i is high while rx_act_i is low is not counted toward C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz symbol clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_act_i | input | 1 | Receive activity on the segment this clock |
| col_i | input | 1 | Collision present this clock |
| link_i | input | 8 | Per-port receive/link status |
| part_i | input | 8 | Per-port partition status |
| iso_i | input | 8 | Per-port isolation status |
| sel_i | input | 3 | Display content select |
| led_o | output | 8 | Indicator line drive |

## Verification
The hardest cases to reach are the exact threshold edges. At an edge, a single active clock more or less in a window moves one bar segment. Random stimulus almost never lands on these exact counts. The bench therefore shortens the window to 200 clocks and runs directed windows with exact activity and collision counts on either side of chosen thresholds. One of these windows also holds col_i high outside the active clocks, which exercises the gating in R9. Randomly loaded windows run between the directed ones, and a mid-window check confirms that the bar holds its value.

// File: rtl/lnm_pkg.sv
package lnm_pkg;
  localparam int unsigned NLED = 8;

  // load thresholds, percent of full window
  function automatic int unsigned util_pct(input int unsigned k);
    case (k)
      0: return 1;
      1: return 3;
      2: return 5;
      3: return 10;
      4: return 20;
      5: return 40;
      6: return 60;
      default: return 80;
    endcase
  endfunction

  // collision thresholds, percent of active clocks
  function automatic int unsigned col_pct(input int unsigned k);
    case (k)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 8;
      5: return 10;
      6: return 15;
      default: return 20;
    endcase
  endfunction
endpackage

// File: rtl/lnm_window.sv
module lnm_window #(
  parameter int unsigned WIN_CLKS = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic win_end_o
);
  localparam int unsigned TW = $clog2(WIN_CLKS);

  logic [TW-1:0] tick_q;

  assign win_end_o = (tick_q == TW'(WIN_CLKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tick_q <= '0;
    else if (win_end_o) tick_q <= '0;
    else                tick_q <= tick_q + 1'b1;
  end
endmodule

// File: rtl/lnm_accum.sv
module lnm_accum #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] sum_o
);
  logic [CW-1:0] cnt_q;

  // sum includes the current clock so the final sample is not lost
  assign sum_o = cnt_q + CW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= sum_o;
  end
endmodule

// File: rtl/lnm_thermo.sv
module lnm_thermo #(
  parameter int unsigned CW      = 8,
  parameter bit          USE_COL = 1'b0
) (
  input  logic [CW-1:0]               num_i,
  input  logic [CW-1:0]               den_i,
  output logic [lnm_pkg::NLED-1:0]    bar_o
);
  localparam int unsigned PW = CW + 8;

  logic den_nz;
  assign den_nz = (den_i != '0);

  for (genvar g = 0; g < int'(lnm_pkg::NLED); g++) begin : g_step
    localparam int unsigned PCT = USE_COL ? lnm_pkg::col_pct(g) : lnm_pkg::util_pct(g);
    logic [PW-1:0] lhs, rhs;
    assign lhs      = PW'(num_i) * PW'(100);
    assign rhs      = PW'(den_i) * PW'(PCT);
    assign bar_o[g] = den_nz && (lhs >= rhs);
  end
endmodule

// File: rtl/net_load_meter.sv
module net_load_meter #(
  parameter int unsigned WIN_CLKS = 25_000_000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_act_i,
  input  logic       col_i,
  input  logic [7:0] link_i,
  input  logic [7:0] part_i,
  input  logic [7:0] iso_i,
  input  logic [2:0] sel_i,
  output logic [7:0] led_o
);
  localparam int unsigned CW = $clog2(WIN_CLKS + 1);

  logic          win_end;
  logic [CW-1:0] act_sum, col_sum;
  logic [7:0]    util_nxt, col_nxt;
  logic [7:0]    util_bar, col_bar;

  lnm_window #(.WIN_CLKS(WIN_CLKS)) i_window (
    .clk_i, .rst_ni, .win_end_o(win_end)
  );

  lnm_accum #(.CW(CW)) i_act_acc (
    .clk_i, .rst_ni, .inc_i(rx_act_i), .clr_i(win_end), .sum_o(act_sum)
  );

  lnm_accum #(.CW(CW)) i_col_acc (
    .clk_i, .rst_ni, .inc_i(rx_act_i & col_i), .clr_i(win_end), .sum_o(col_sum)
  );

  lnm_thermo #(.CW(CW), .USE_COL(1'b0)) i_util_cmp (
    .num_i(act_sum), .den_i(CW'(WIN_CLKS)), .bar_o(util_nxt)
  );

  lnm_thermo #(.CW(CW), .USE_COL(1'b1)) i_col_cmp (
    .num_i(col_sum), .den_i(act_sum), .bar_o(col_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      util_bar <= '0;
      col_bar  <= '0;
    end else if (win_end) begin
      util_bar <= util_nxt;
      col_bar  <= col_nxt;
    end
  end

  always_comb begin
    case (sel_i)
      3'd0:    led_o = link_i;
      3'd1:    led_o = part_i;
      3'd2:    led_o = iso_i;
      3'd3:    led_o = util_bar;
      3'd4:    led_o = col_bar;
      default: led_o = '0;
    endcase
  end
endmodule

// File: rtl/lnm_checker.sv
module lnm_checker #(
  parameter int unsigned WIN_CLKS = 25_000_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] sel_i,
  input logic [7:0] led_o,
  input logic       win_end,
  input logic [7:0] util_bar,
  input logic [7:0] col_bar
);
  int unsigned since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      since_q <= 0;
    else if (win_end) since_q <= 0;
    else              since_q <= since_q + 1;
  end

  p_period_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end |-> (since_q == WIN_CLKS - 1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> ($stable(util_bar) && $stable(col_bar)));

  p_util_thermo_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (8'(util_bar + 8'd1) & util_bar) == 8'd0);

  p_col_thermo_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (8'(col_bar + 8'd1) & col_bar) == 8'd0);

  p_dark_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i >= 3'd5) |-> (led_o == 8'd0));

  p_bar_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'd3) |-> (led_o == util_bar));
endmodule

bind net_load_meter lnm_checker #(.WIN_CLKS(WIN_CLKS)) i_lnm_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .led_o   (led_o),
  .win_end (win_end),
  .util_bar(util_bar),
  .col_bar (col_bar)
);

// File: tb/test_net_load_meter.sv
`timescale 1ns/1ps
module test_net_load_meter;
  localparam int WIN = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_act = 1'b0, col = 1'b0;
  logic [7:0] link = '0, part = '0, iso = '0;
  logic [2:0] sel = 3'd3;
  logic [7:0] led;

  int checks = 0, errors = 0;
  logic [7:0] prev_util = '0;

  always #2.5 clk = ~clk;

  net_load_meter #(.WIN_CLKS(WIN)) i_net_load_meter (
    .clk_i(clk), .rst_ni(rst_n), .rx_act_i(rx_act), .col_i(col),
    .link_i(link), .part_i(part), .iso_i(iso), .sel_i(sel), .led_o(led)
  );

  function automatic int up(int k);
    int t[8] = '{1, 3, 5, 10, 20, 40, 60, 80};
    return t[k];
  endfunction

  function automatic int cp(int k);
    int t[8] = '{1, 2, 4, 6, 8, 10, 15, 20};
    return t[k];
  endfunction

  function automatic logic [7:0] exp_util(int a);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++) if (a * 100 >= up(k) * WIN) r[k] = 1'b1;
    return r;
  endfunction

  function automatic logic [7:0] exp_col(int a, int c);
    logic [7:0] r = '0;
    for (int k = 0; k < 8; k++) if (a != 0 && c * 100 >= cp(k) * a) r[k] = 1'b1;
    return r;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic look(logic [2:0] s, string req, logic [7:0] exp);
    sel = s;
    #0.2;
    check(req, led, exp);
  endtask

  // directed: first n_act clocks active, first n_col of them colliding;
  // stray drives col high while rx is idle; pa/pc >= 0 selects random mode
  task automatic run_window(int n_act, int n_col, bit stray, int pa, int pc);
    int a = 0, c = 0;
    for (int t = 0; t < WIN; t++) begin
      if (t == WIN / 2) begin
        sel = 3'd3;
        #0.2;
        check("R2 hold", led, prev_util);
      end
      if (pa >= 0) begin
        rx_act = ($urandom_range(99) < pa);
        col    = ($urandom_range(99) < pc);
      end else begin
        rx_act = (t < n_act);
        col    = (t < n_col) || (stray && t >= n_act);
      end
      if (rx_act) a++;
      if (rx_act && col) c++;
      @(negedge clk);
    end
    rx_act = 1'b0;
    col = 1'b0;
    look(3'd3, "R3/R4 util", exp_util(a));
    look(3'd4, "R5/R6/R9 col", exp_col(a, c));
    prev_util = exp_util(a);
    sel = 3'd3;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    look(3'd3, "R1 util in reset", 8'd0);
    look(3'd4, "R1 col in reset", 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    look(3'd3, "R1 util after reset", 8'd0);
    sel = 3'd3;

    // R7 select mapping
    for (int i = 0; i < 4; i++) begin
      link = 8'($urandom); part = 8'($urandom); iso = 8'($urandom);
      look(3'd0, "R7 link", link);
      look(3'd1, "R7 part", part);
      look(3'd2, "R7 iso", iso);
      look(3'd5, "R7 dark5", 8'd0);
      look(3'd6, "R7 dark6", 8'd0);
      look(3'd7, "R7 dark7", 8'd0);
    end
    sel = 3'd3;

    // first window is partly consumed by the above (<1 clock), realign
    // by running it with no activity
    run_window(0, 0, 1'b0, -1, 0);
    // R3 edges: 1% = 2 clocks, 80% = 160 clocks
    run_window(1, 0, 1'b0, -1, 0);
    run_window(2, 0, 1'b0, -1, 0);
    run_window(119, 0, 1'b0, -1, 0);
    run_window(120, 0, 1'b0, -1, 0);
    run_window(159, 0, 1'b0, -1, 0);
    run_window(160, 0, 1'b0, -1, 0);
    run_window(WIN, 0, 1'b0, -1, 0);
    // R8: idle after full
    run_window(0, 0, 1'b0, -1, 0);
    // R5 edges at A=100: 15% and 20%
    run_window(100, 14, 1'b0, -1, 0);
    run_window(100, 15, 1'b0, -1, 0);
    run_window(100, 19, 1'b0, -1, 0);
    run_window(100, 20, 1'b0, -1, 0);
    // R9: stray collisions outside activity
    run_window(100, 5, 1'b1, -1, 0);
    // R6: collisions with no activity
    run_window(0, 0, 1'b1, -1, 0);
    // random loads
    for (int w = 0; w < 16; w++) begin
      int pa_r = $urandom_range(100);
      int pc_r = $urandom_range(30);
      run_window(0, 0, 1'b0, pa_r, pc_r);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule